// File: doc/BRIEF.md
# Local Interval Timer Channel

This block is a single timer channel meant to be dedicated to one processor core. It holds a tick down-counter and an interrupt down-counter, each reloaded from its own buffer register. The tick counter divides the clock; each time it wraps it steps the interrupt counter once. When the interrupt counter runs out, the channel latches an interrupt flag. In interval mode the channel then reloads and keeps running. In one-shot mode it turns itself off.

Software reaches the channel through a 32-bit register bus with byte offsets inside a 256-byte window. Writes to the two buffers and to the control register do not take effect at once. They are staged and applied a fixed number of cycles later. Each apply sets a write-status bit that software polls and then clears by writing 1 to it. A single interrupt line is the latched flag gated by an enable bit.

Top module: `lt_chan_timer`

## Requirements
- R1: After reset every register, both counters, all status bits and `irq_o` read as zero.
- R2: A write to the tick buffer (offset 0x00), the interrupt-count buffer (0x08) or control (0x20) takes effect exactly WR_DLY clock edges after the bus edge that carried it. Until then, reads return the old value. A second write to the same register before the apply replaces the staged value and restarts the delay.
- R3: Write-status register (0x40): bit 0 sets when a tick-buffer write is applied, bit 1 when an interrupt-count-buffer write is applied, and bit 3 when a control write is applied. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a set on the same edge wins over a clear.
- R4: Applying a tick-buffer write also loads the tick counter (readable at 0x04). While control bit 0 is 1, the tick counter decrements every cycle and reloads from the buffer when it is zero. With buffer value T, it therefore wraps once every T+1 cycles.
- R5: The interrupt counter (readable at 0x0C) is loaded when an interrupt-count-buffer write is applied. It changes only on a tick-counter wrap while control bit 1 is 1. A wrap that finds it at zero is an expiry. With buffers T and I, the first expiry lands (T+1)(I+1) edges after control is applied.
- R6: In interval mode (control bit 2 = 1), an expiry reloads the interrupt counter from its buffer, so expiries repeat every (T+1)(I+1) cycles.
- R7: In one-shot mode (control bit 2 = 0), an expiry clears control bits 0 and 1 in hardware, and both counters then hold.
- R8: Interrupt status bit 0 (0x30) sets on an expiry and is cleared by writing 1 to it; a set on the same edge wins.
- R9: `irq_o` is high exactly when interrupt status bit 0 and enable bit 0 (0x34) are both 1. The enable write takes effect on the bus edge.
- R10: Software writing 0 to control bits 0 and 1 stops the channel, and both counters hold their values.
- R11: A read of an offset outside the map returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest timing points are the exact apply edge of a staged write and the exact edge of the first expiry. A design that is one cycle off in the delay, in the T+1 wrap or in the (I+1) count raises the interrupt or the status bit one edge early or late, and the bench samples on both sides of the predicted edge. A second write landing while the first is still staged must win; a design that applies the first value, or keeps the old countdown, shows the stale value or an early status bit. One-shot expiry must turn off the run bits and freeze the counters, and a design that forgets this keeps counting. The enable gate, halted counters and a non-counting interrupt counter while only the timer runs are each read back through the bus.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int BUS_W = 32;

  localparam logic [7:0] OFF_TBUF = 8'h00;
  localparam logic [7:0] OFF_TCNT = 8'h04;
  localparam logic [7:0] OFF_IBUF = 8'h08;
  localparam logic [7:0] OFF_ICNT = 8'h0C;
  localparam logic [7:0] OFF_CTRL = 8'h20;
  localparam logic [7:0] OFF_IST  = 8'h30;
  localparam logic [7:0] OFF_IEN  = 8'h34;
  localparam logic [7:0] OFF_WST  = 8'h40;

  localparam int WST_TBUF = 0;
  localparam int WST_IBUF = 1;
  localparam int WST_CTRL = 3;

  // control layout: [2] reload, [1] interrupt counter run, [0] timer run
  typedef struct packed {
    logic reload;
    logic irq_run;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/lt_wr_delay.sv
// Staging slot: holds one written value and applies it DLY edges later.
module lt_wr_delay #(
  parameter int W   = 32,
  parameter int DLY = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic         apply_o,
  output logic [W-1:0] data_o
);
  localparam int CW = $clog2(DLY) + 1;

  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  data_q, data_d;

  // a new write at the apply edge cancels the apply and restarts
  assign apply_o = pend_q && (cnt_q == '0) && !wr_i;
  assign data_o  = data_q;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    data_d = data_q;
    if (wr_i) begin
      pend_d = 1'b1;
      cnt_d  = CW'(DLY - 1);
      data_d = data_i;
    end else if (pend_q) begin
      if (cnt_q == '0) pend_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/lt_counters.sv
// Tick divider followed by interrupt counter.
module lt_counters #(
  parameter int CNT_W  = 32,
  parameter int ICNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              irq_run_i,
  input  logic              reload_i,
  input  logic              tload_i,
  input  logic [CNT_W-1:0]  tload_val_i,
  input  logic              iload_i,
  input  logic [ICNT_W-1:0] iload_val_i,
  input  logic [CNT_W-1:0]  tbuf_i,
  input  logic [ICNT_W-1:0] ibuf_i,
  output logic [CNT_W-1:0]  tcnt_o,
  output logic [ICNT_W-1:0] icnt_o,
  output logic              expire_o
);
  logic [CNT_W-1:0]  tcnt_q, tcnt_d;
  logic [ICNT_W-1:0] icnt_q, icnt_d;
  logic              wrap;

  assign wrap     = run_i && (tcnt_q == '0);
  assign expire_o = wrap && irq_run_i && (icnt_q == '0);
  assign tcnt_o   = tcnt_q;
  assign icnt_o   = icnt_q;

  always_comb begin
    tcnt_d = tcnt_q;
    if (tload_i)       tcnt_d = tload_val_i;
    else if (wrap)     tcnt_d = tbuf_i;
    else if (run_i)    tcnt_d = tcnt_q - 1'b1;
  end

  always_comb begin
    icnt_d = icnt_q;
    if (iload_i) begin
      icnt_d = iload_val_i;
    end else if (wrap && irq_run_i) begin
      if (icnt_q != '0)  icnt_d = icnt_q - 1'b1;
      else if (reload_i) icnt_d = ibuf_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      icnt_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      icnt_q <= icnt_d;
    end
  end
endmodule

// File: rtl/lt_chan_timer.sv
module lt_chan_timer
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ICNT_W = 32,
  parameter int WR_DLY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_i,
  input  logic [7:0]       bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             irq_o
);
  logic sel_tbuf, sel_ibuf, sel_ctrl, sel_ist, sel_ien, sel_wst;
  assign sel_tbuf = bus_wr_i && (bus_addr_i == OFF_TBUF);
  assign sel_ibuf = bus_wr_i && (bus_addr_i == OFF_IBUF);
  assign sel_ctrl = bus_wr_i && (bus_addr_i == OFF_CTRL);
  assign sel_ist  = bus_wr_i && (bus_addr_i == OFF_IST);
  assign sel_ien  = bus_wr_i && (bus_addr_i == OFF_IEN);
  assign sel_wst  = bus_wr_i && (bus_addr_i == OFF_WST);

  logic              tbuf_apply, ibuf_apply, ctrl_apply;
  logic [CNT_W-1:0]  tbuf_stg;
  logic [ICNT_W-1:0] ibuf_stg;
  logic [2:0]        ctrl_stg;

  lt_wr_delay #(.W(CNT_W), .DLY(WR_DLY)) u_tbuf_dly (
    .clk(clk), .rst_n(rst_n), .wr_i(sel_tbuf), .data_i(bus_wdata_i[CNT_W-1:0]),
    .apply_o(tbuf_apply), .data_o(tbuf_stg));
  lt_wr_delay #(.W(ICNT_W), .DLY(WR_DLY)) u_ibuf_dly (
    .clk(clk), .rst_n(rst_n), .wr_i(sel_ibuf), .data_i(bus_wdata_i[ICNT_W-1:0]),
    .apply_o(ibuf_apply), .data_o(ibuf_stg));
  lt_wr_delay #(.W(3), .DLY(WR_DLY)) u_ctrl_dly (
    .clk(clk), .rst_n(rst_n), .wr_i(sel_ctrl), .data_i(bus_wdata_i[2:0]),
    .apply_o(ctrl_apply), .data_o(ctrl_stg));

  logic [CNT_W-1:0]  tbuf_q, tbuf_d;
  logic [ICNT_W-1:0] ibuf_q, ibuf_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              ist_q, ist_d, ien_q, ien_d;
  logic [3:0]        wst_q, wst_d;
  logic [CNT_W-1:0]  tcnt;
  logic [ICNT_W-1:0] icnt;
  logic              expire;

  lt_counters #(.CNT_W(CNT_W), .ICNT_W(ICNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .run_i(ctrl_q.run), .irq_run_i(ctrl_q.irq_run), .reload_i(ctrl_q.reload),
    .tload_i(tbuf_apply), .tload_val_i(tbuf_stg),
    .iload_i(ibuf_apply), .iload_val_i(ibuf_stg),
    .tbuf_i(tbuf_q), .ibuf_i(ibuf_q),
    .tcnt_o(tcnt), .icnt_o(icnt), .expire_o(expire));

  always_comb begin
    tbuf_d = tbuf_apply ? tbuf_stg : tbuf_q;
    ibuf_d = ibuf_apply ? ibuf_stg : ibuf_q;

    ctrl_d = ctrl_q;
    if (ctrl_apply) begin
      ctrl_d = ctrl_t'(ctrl_stg);
    end else if (expire && !ctrl_q.reload) begin
      ctrl_d.run     = 1'b0;
      ctrl_d.irq_run = 1'b0;
    end

    ist_d = ist_q;
    if (sel_ist && bus_wdata_i[0]) ist_d = 1'b0;
    if (expire)                    ist_d = 1'b1;

    ien_d = sel_ien ? bus_wdata_i[0] : ien_q;

    wst_d = wst_q;
    if (sel_wst) begin
      wst_d[WST_TBUF] = wst_q[WST_TBUF] & ~bus_wdata_i[WST_TBUF];
      wst_d[WST_IBUF] = wst_q[WST_IBUF] & ~bus_wdata_i[WST_IBUF];
      wst_d[WST_CTRL] = wst_q[WST_CTRL] & ~bus_wdata_i[WST_CTRL];
    end
    if (tbuf_apply) wst_d[WST_TBUF] = 1'b1;
    if (ibuf_apply) wst_d[WST_IBUF] = 1'b1;
    if (ctrl_apply) wst_d[WST_CTRL] = 1'b1;
    wst_d[2] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf_q <= '0;
      ibuf_q <= '0;
      ctrl_q <= '0;
      ist_q  <= 1'b0;
      ien_q  <= 1'b0;
      wst_q  <= '0;
    end else begin
      tbuf_q <= tbuf_d;
      ibuf_q <= ibuf_d;
      ctrl_q <= ctrl_d;
      ist_q  <= ist_d;
      ien_q  <= ien_d;
      wst_q  <= wst_d;
    end
  end

  assign irq_o = ist_q & ien_q;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFF_TBUF: bus_rdata_o = BUS_W'(tbuf_q);
      OFF_TCNT: bus_rdata_o = BUS_W'(tcnt);
      OFF_IBUF: bus_rdata_o = BUS_W'(ibuf_q);
      OFF_ICNT: bus_rdata_o = BUS_W'(icnt);
      OFF_CTRL: bus_rdata_o = BUS_W'(ctrl_q);
      OFF_IST:  bus_rdata_o = BUS_W'(ist_q);
      OFF_IEN:  bus_rdata_o = BUS_W'(ien_q);
      OFF_WST:  bus_rdata_o = BUS_W'(wst_q);
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lt_chan_timer_chk.sv
module lt_chan_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int ICNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        ctrl,
  input logic [CNT_W-1:0]  tcnt,
  input logic [ICNT_W-1:0] icnt,
  input logic              tload,
  input logic              iload,
  input logic              ctrl_apply,
  input logic              expire,
  input logic              ist,
  input logic              ien,
  input logic [3:0]        wst,
  input logic              irq_o
);
  // R4
  tick_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && tcnt != '0 && !tload) |=> (tcnt == $past(tcnt) - CNT_W'(1)));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !tload) |=> $stable(tcnt));

  // R5
  icnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[1] && !iload) |=> $stable(icnt));

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl[2] && !ctrl_apply) |=> (ctrl[1:0] == 2'b00));

  // R8
  expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ist);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ien && ist));

  // R3
  wst_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wst[0]) |-> $past(tload));
endmodule

bind lt_chan_timer lt_chan_timer_chk #(.CNT_W(CNT_W), .ICNT_W(ICNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .tcnt(tcnt), .icnt(icnt),
  .tload(tbuf_apply), .iload(ibuf_apply), .ctrl_apply(ctrl_apply),
  .expire(expire), .ist(ist_q), .ien(ien_q), .wst(wst_q), .irq_o(irq_o));

// File: tb/lt_chan_timer_tb_top.sv
module lt_chan_timer_tb_top;
  localparam int D = 3;

  logic        clk, rst_n, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int checks, failures, cyc, last_w;
  bit done;

  lt_chan_timer #(.CNT_W(32), .ICNT_W(32), .WR_DLY(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  function automatic int expiry_span(int t, int i);
    return (t + 1) * (i + 1);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    last_w = cyc;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    int w1, w2, wc, e1, p, t, i;
    bit ivl;
    checks = 0; failures = 0; done = 0;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    void'($urandom(32'd4242));
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    foreach (v[k]) begin end
    for (int a = 0; a <= 8'h40; a += 4) begin
      rd(8'(a), v);
      chk(v == 0, "R1", $sformatf("reg 0x%0h", a), v, 0);
    end
    chk(irq == 0, "R1", "irq", irq, 0);

    // R2/R3/R4 tick buffer apply timing
    wr(8'h00, 32'd5); w1 = last_w;
    wait_to(w1 + D - 1);
    rd(8'h00, v); chk(v == 0, "R2", "tbuf before apply", v, 0);
    rd(8'h40, v); chk(v == 0, "R3", "wst before apply", v, 0);
    wait_to(w1 + D);
    rd(8'h00, v); chk(v == 5, "R2", "tbuf after apply", v, 5);
    rd(8'h40, v); chk(v == 1, "R3", "wst bit0", v, 1);
    rd(8'h04, v); chk(v == 5, "R4", "tcnt loaded", v, 5);
    wr(8'h40, 32'h0);
    rd(8'h40, v); chk(v == 1, "R3", "wst write 0 keeps", v, 1);
    wr(8'h40, 32'h1);
    rd(8'h40, v); chk(v == 0, "R3", "wst W1C", v, 0);

    // R2 second write while staged replaces and restarts
    wr(8'h08, 32'd9); w1 = last_w;
    wr(8'h08, 32'd2); w2 = last_w;
    wait_to(w1 + D);
    rd(8'h08, v); chk(v == 0, "R2", "ibuf not yet applied", v, 0);
    rd(8'h40, v); chk(v == 0, "R3", "wst bit1 not yet", v, 0);
    wait_to(w2 + D - 1);
    rd(8'h08, v); chk(v == 0, "R2", "ibuf one before", v, 0);
    wait_to(w2 + D);
    rd(8'h08, v); chk(v == 2, "R2", "ibuf replaced", v, 2);
    rd(8'h40, v); chk(v == 2, "R3", "wst bit1", v, 2);
    rd(8'h0C, v); chk(v == 2, "R5", "icnt loaded", v, 2);
    wr(8'h40, 32'hB);

    // R5/R6/R7 random runs
    for (int it = 0; it < 8; it++) begin
      t = int'($urandom % 6) + 1;
      i = int'($urandom % 3) + 1;
      ivl = it[0];
      wr(8'h20, 32'h0);
      repeat (D + 1) @(negedge clk);
      wr(8'h30, 32'h1);
      wr(8'h40, 32'hB);
      wr(8'h34, 32'h1);
      wr(8'h00, 32'(t));
      wr(8'h08, 32'(i));
      wr(8'h20, ivl ? 32'h7 : 32'h3); wc = last_w;
      p  = expiry_span(t, i);
      e1 = wc + D + p;
      rd(8'h40, v);
      wait_to(e1 - 1);
      chk(irq == 0, "R5", "irq one edge early", irq, 0);
      wait_to(e1);
      chk(irq == 1, "R5", "irq at expiry", irq, 1);
      if (!ivl) begin
        rd(8'h20, v); chk(v[1:0] == 0, "R7", "run bits cleared", v[1:0], 0);
        rd(8'h04, v);
        repeat (4) @(negedge clk);
        rd(8'h04, v2); chk(v2 == v, "R7", "tcnt frozen", v2, v);
      end else begin
        wr(8'h30, 32'h1);
        chk(irq == 0, "R8", "status W1C", irq, 0);
        wait_to(e1 + p - 1);
        chk(irq == 0, "R6", "irq before second", irq, 0);
        wait_to(e1 + p);
        chk(irq == 1, "R6", "second expiry", irq, 1);
      end
    end

    // R9 enable gating
    wr(8'h20, 32'h0);
    repeat (D + 1) @(negedge clk);
    wr(8'h34, 32'h0);
    wr(8'h30, 32'h1);
    wr(8'h00, 32'd1);
    wr(8'h08, 32'd0);
    wr(8'h20, 32'h3); wc = last_w;
    wait_to(wc + D + expiry_span(1, 0) + 1);
    rd(8'h30, v); chk(v == 1, "R8", "status set", v, 1);
    chk(irq == 0, "R9", "irq masked", irq, 0);
    wr(8'h34, 32'h1);
    chk(irq == 1, "R9", "irq on enable", irq, 1);
    wr(8'h30, 32'h1);
    chk(irq == 0, "R9", "irq after clear", irq, 0);

    // R5/R10 timer only, then stop
    wr(8'h08, 32'd6);
    wr(8'h00, 32'd3);
    wr(8'h20, 32'h1);
    repeat (D + 2) @(negedge clk);
    rd(8'h04, v);
    @(negedge clk);
    rd(8'h04, v2); chk(v2 != v, "R4", "tcnt moving", v2, v);
    repeat (9) @(negedge clk);
    rd(8'h0C, v); chk(v == 6, "R5", "icnt idle without bit1", v, 6);
    rd(8'h30, v); chk(v == 0, "R5", "no expiry without bit1", v, 0);
    wr(8'h20, 32'h0);
    repeat (D + 1) @(negedge clk);
    rd(8'h04, v);
    repeat (5) @(negedge clk);
    rd(8'h04, v2); chk(v2 == v, "R10", "tcnt held", v2, v);

    // R11 unmapped
    rd(8'h50, v); chk(v == 0, "R11", "unmapped 0x50", v, 0);
    rd(8'h24, v); chk(v == 0, "R11", "unmapped 0x24", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule